// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment:offset pair into a 20-bit physical byte address, the way a real-mode processor front end does before a memory access goes out. It keeps four 16-bit segment registers (code, data, stack and extra). A write port loads them. Each translation request gives an access kind and a 16-bit offset. It may also carry a segment override.

The block picks the segment register implied by the access kind. Only a data access may name a different register through the override. The chosen segment is shifted left by four bits and the offset is added to it. Any carry beyond bit 19 is dropped, so addresses wrap within 1 MB. The result and its valid flag come out registered, one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, all four segment registers clear to 0000h and `addr_valid` is 0. A code request at offset 0000h issued after reset, before any register write, yields address 00000h.
- R2: The physical address is the selected segment times 16 plus the zero-extended offset, truncated to 20 bits.
- R3: `addr_valid` equals the previous cycle's `req_valid`. `addr_out` is updated only in the cycle after a request and holds its value otherwise.
- R4: An access with `req_kind` 0 (code fetch) uses the code segment register.
- R5: An access with `req_kind` 1 (data) and `ovr_en` 0 uses the data segment register. `req_kind` 3 is reserved and behaves as a code fetch.
- R6: An access with `req_kind` 2 (stack) uses the stack segment register.
- R7: A data access with `ovr_en` 1 uses the register named by `ovr_sel` (0 code, 1 data, 2 stack, 3 extra).
- R8: `ovr_en` and `ovr_sel` have no effect on code or stack accesses.
- R9: A carry out of bit 19 is discarded; FFFFh:0010h gives 00000h.
- R10: When a register write and a request fall in the same cycle, the request uses the old register value. The written value applies from the next cycle.
- R11: With `wr_en` 1, `wr_data` is loaded into the register named by `wr_sel` (0 code, 1 data, 2 stack, 3 extra) at the clock edge.
- R12: Different pairs may alias the same address: A000h:5677h and A111h:4567h both give A5677h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access kind (0 code, 1 data, 2 stack) |
| ovr_en | input | 1 | Override present |
| ovr_sel | input | 2 | Override register (0 code, 1 data, 2 stack, 3 extra) |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Registered request valid |
| addr_out | output | 20 | Registered physical address |

## Verification
Each of the four registers is loaded with a different value. A request can then only produce the expected address if the right register was chosen, so swapped defaults or a misrouted override show up as a wrong address.

The offsets include all-zero, all-one and carry-producing values. These separate a true shift-and-add from an OR-merge, and the 21st bit being dropped from kept. The aliasing pair and the wrap case pin down the arithmetic.

A write in the same cycle as a request tells old-value from bypass behaviour. Idle cycles show that the output holds its value.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int NSEG   = 4;
  localparam int SEL_W  = $clog2(NSEG);

  typedef enum logic [1:0] {
    KIND_CODE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_idx_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     wr_sel,
  input  logic [W-1:0]      wr_data,
  output logic [N-1:0][W-1:0] seg_q
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    logic         ld;
    logic [W-1:0] nxt;

    always_comb begin
      ld  = wr_en && (wr_sel == SW'(i));
      nxt = ld ? wr_data : seg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[i] <= '0;
      else if (ld) seg_q[i] <= nxt;
    end

    // R11: a write lands in the addressed register on the next edge
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SW'(i)) |=> (seg_q[i] == $past(wr_data)));
    // R10/R11: untouched registers keep their value
    p_hold_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SW'(i)) |=> $stable(seg_q[i]));
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] seg_q,
  input  logic [1:0]          req_kind,
  input  logic                ovr_en,
  input  logic [SW-1:0]       ovr_sel,
  output logic [W-1:0]        seg_out
);
  logic [SW-1:0] dflt_idx;
  logic [SW-1:0] eff_idx;

  always_comb begin
    unique case (acc_kind_e'(req_kind))
      KIND_DATA:  dflt_idx = SW'(SEG_DATA);
      KIND_STACK: dflt_idx = SW'(SEG_STACK);
      default:    dflt_idx = SW'(SEG_CODE);
    endcase
    eff_idx = (acc_kind_e'(req_kind) == KIND_DATA && ovr_en) ? ovr_sel : dflt_idx;
    seg_out = seg_q[eff_idx];
  end

  // R8: override never reroutes a non-data access
  always_comb begin
    if (acc_kind_e'(req_kind) != KIND_DATA)
      a_no_ovr_r8: assert (eff_idx != SW'(SEG_EXTRA));
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder
  import seg_pkg::*;
#(
  parameter int SW_  = SEG_W,
  parameter int OW   = OFF_W,
  parameter int SH   = SHIFT,
  localparam int AW  = SW_ + SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [SW_-1:0] seg_in,
  input  logic [OW-1:0] off_in,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] base_w;
  logic [AW-1:0] off_w;
  logic [AW-1:0] sum_nxt;

  always_comb begin
    base_w  = {seg_in, {SH{1'b0}}};
    off_w   = AW'(off_in);
    sum_nxt = base_w + off_w;  // carry past the top bit is dropped
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= sum_nxt;
    end
  end

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && $stable(addr_out)));
  // R9: the low offset nibble passes through untouched by the shifted base
  p_low_nibble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_out[SH-1:0] == $past(off_in[SH-1:0])));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_sel,
  input  logic [15:0] req_offset,
  output logic        addr_valid,
  output logic [19:0] addr_out
);
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]           seg_pick;

  seg_regfile #(.W(SEG_W), .N(NSEG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .seg_q   (seg_q)
  );

  seg_select #(.W(SEG_W), .N(NSEG)) u_sel (
    .seg_q    (seg_q),
    .req_kind (req_kind),
    .ovr_en   (ovr_en),
    .ovr_sel  (ovr_sel),
    .seg_out  (seg_pick)
  );

  seg_adder #(.SW_(SEG_W), .OW(OFF_W), .SH(SHIFT)) u_add (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .seg_in     (seg_pick),
    .off_in     (req_offset),
    .addr_valid (addr_valid),
    .addr_out   (addr_out)
  );

  // R4/R8: code fetch address built from the code register regardless of override
  p_code_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=>
      (addr_out == ADDR_W'({$past(seg_q[0]), 4'h0} + ADDR_W'($past(req_offset)))));
  // R6: stack address built from the stack register
  p_stack_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |=>
      (addr_out == ADDR_W'({$past(seg_q[2]), 4'h0} + ADDR_W'($past(req_offset)))));
  // R5: plain data address built from the data register
  p_data_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && !ovr_en) |=>
      (addr_out == ADDR_W'({$past(seg_q[1]), 4'h0} + ADDR_W'($past(req_offset)))));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        ovr_en;
  logic [1:0]  ovr_sel;
  logic [15:0] req_offset;
  logic        addr_valid;
  logic [19:0] addr_out;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .req_offset(req_offset), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  // vector: req[44:41] kind[40:39] oen[38] osel[37:36] off[35:20] exp[19:0]
  // segments preloaded: code A000, data A111, stack FFFF, extra 1234
  localparam logic [44:0] VEC [10] = '{
    {4'd12, 2'd0, 1'b0, 2'd0, 16'h5677, 20'hA5677}, // R12 R4 code alias
    {4'd12, 2'd1, 1'b0, 2'd0, 16'h4567, 20'hA5677}, // R12 R5 data alias
    {4'd9,  2'd2, 1'b0, 2'd0, 16'h0010, 20'h00000}, // R9 R6 wrap
    {4'd7,  2'd1, 1'b1, 2'd3, 16'h0001, 20'h12341}, // R7 extra
    {4'd7,  2'd1, 1'b1, 2'd0, 16'h0000, 20'hA0000}, // R7 code
    {4'd7,  2'd1, 1'b1, 2'd2, 16'h000F, 20'hFFFFF}, // R7 stack
    {4'd2,  2'd1, 1'b1, 2'd1, 16'hFFFF, 20'hB110F}, // R2 carry into high bits
    {4'd8,  2'd0, 1'b1, 2'd3, 16'h0001, 20'hA0001}, // R8 code ignores override
    {4'd8,  2'd2, 1'b1, 2'd1, 16'h0002, 20'hFFFF2}, // R8 stack ignores override
    {4'd5,  2'd3, 1'b0, 2'd0, 16'h0003, 20'hA0003}  // R5 reserved kind acts as code
  };

  task automatic check(input int req, input logic [19:0] act, input logic [19:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %05h expected %05h", req, act, exp);
    end
  endtask

  task automatic seg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drives a request at a falling edge, returns result one cycle later
  task automatic xlate(input logic [1:0] k, input logic oe, input logic [1:0] os,
                       input logic [15:0] off, output logic [19:0] res, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; ovr_en = oe; ovr_sel = os; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    res = addr_out; v = addr_valid;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] r;
    logic        v;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_kind = '0; ovr_en = 1'b0; ovr_sel = '0; req_offset = '0;
    repeat (3) @(negedge clk);
    check(1, {19'd0, addr_valid}, 20'd0);  // R1 valid low in reset
    rst_n = 1'b1;

    // R1: registers zero after reset
    xlate(2'd0, 1'b0, 2'd0, 16'h0000, r, v);
    check(1, r, 20'h00000);
    check(3, {19'd0, v}, 20'd1);           // R3 valid one cycle later
    xlate(2'd2, 1'b0, 2'd0, 16'h1234, r, v);
    check(1, r, 20'h01234);                // R1 stack also zero

    // R11: load each register
    seg_write(2'd0, 16'hA000);
    seg_write(2'd1, 16'hA111);
    seg_write(2'd2, 16'hFFFF);
    seg_write(2'd3, 16'h1234);

    for (int i = 0; i < 10; i++) begin
      logic [44:0] e;
      e = VEC[i];
      xlate(e[40:39], e[38], e[37:36], e[35:20], r, v);
      check(int'(e[44:41]), r, e[19:0]);
    end

    // R11: extra register written independently of others
    xlate(2'd1, 1'b1, 2'd3, 16'h0000, r, v);
    check(11, r, 20'h12340);

    // R3: idle cycle drops valid and holds address
    @(negedge clk);
    check(3, {19'd0, addr_valid}, 20'd0);
    check(3, addr_out, 20'h12340);

    // R10: write and request in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h5000;
    req_valid = 1'b1; req_kind = 2'd1; ovr_en = 1'b0; req_offset = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    check(10, addr_out, 20'hA1110);        // old data segment used
    @(negedge clk);
    req_valid = 1'b0;
    check(10, addr_out, 20'h50000);        // new value next cycle

    // R1: reset mid-run clears registers and valid
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, {19'd0, addr_valid}, 20'd0);
    rst_n = 1'b1;
    xlate(2'd1, 1'b0, 2'd0, 16'h0042, r, v);
    check(1, r, 20'h00042);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule